// File: doc/BRIEF.md
# Packed-Decimal Payload Length Counter

This block sits beside the transmit path of a framed serial link and counts the data bytes of each outgoing message. It keeps the count directly as four packed decimal digits, one per nibble, so the value is ready to go out as a two-byte length field without a binary-to-decimal conversion. A payload of 150 bytes yields the byte pair 0x01, 0x50; a payload of 35 bytes yields 0x00, 0x35.

The framing logic marks the data bytes with a valid strobe and flags the first and last of them. It drops the valid strobe for the trailer: the end-of-text byte and the check byte. Those bytes are therefore never counted. One cycle after the last data byte, a done strobe says the field is final. The count holds at 9999 with a sticky overflow flag. Each stored digit is also offered as an ASCII character for a debug display.

Top module: `lenfield_bcd`

## Requirements
- R1: After reset the packed count reads 0x0000, and both done and overflow are low.
- R2: A valid byte that carries the first flag sets the count to 0x0001 and clears the overflow flag, whatever the count was before.
- R3: Every further valid byte adds one in decimal. A digit at 9 rolls to 0 and carries into the next digit, so every nibble of the count stays in the range 0 to 9.
- R4: While valid is low, the count, the overflow flag and done do not react to the first or last flags. This is how trailer bytes are kept out of the count.
- R5: len_hi carries the thousands digit in bits 7:4 and the hundreds digit in bits 3:0. len_lo carries the tens digit in bits 7:4 and the ones digit in bits 3:0. len_hi is the byte sent first.
- R6: A valid non-first byte that arrives while the count is 9999 leaves the count at 9999 and sets the overflow flag. The flag stays set until the next first byte.
- R7: done is high in exactly the cycle after a valid byte with the last flag, and low otherwise. A single byte carrying both flags gives a count of 1 with done.
- R8: dbg_ascii holds four characters, each equal to 0x30 plus one digit. The thousands digit is in bits 31:24 and the ones digit in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A payload byte is present this cycle |
| in_first | input | 1 | This valid byte is the first of the payload |
| in_last | input | 1 | This valid byte is the last of the payload |
| len_bcd | output | 16 | Packed decimal count, four digits |
| len_hi | output | 8 | Length byte sent first (thousands, hundreds) |
| len_lo | output | 8 | Length byte sent second (tens, ones) |
| done | output | 1 | One-cycle strobe after the last payload byte |
| overflow | output | 1 | Sticky: count saturated at 9999 |
| dbg_ascii | output | 32 | ASCII character of each digit |

## Verification
The assertions assume that each message opens with a valid byte carrying the first flag. They also assume that the first and last flags mean something only while valid is high. Without these, the saturation and done properties would have no defined starting point.

The driver follows a fixed pattern. It raises the first flag only on the opening byte and the last flag only on the closing byte. It leaves at least one idle cycle between messages, so done pulses never touch each other. During those idle cycles it waves the flags with valid held low, to show that the flags are ignored.

// File: rtl/bcdlen_pkg.sv
package bcdlen_pkg;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [3:0]  DIGIT_MAX  = 4'd9;
  localparam logic [7:0]  ASCII_ZERO = 8'h30;
endpackage

// File: rtl/lenfield_rst_sync.sv
module lenfield_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/lenfield_digit.sv
module lenfield_digit
  import bcdlen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIGIT_W-1:0] start_val,
  input  logic               carry_in,
  output logic [DIGIT_W-1:0] q,
  output logic               at_max,
  output logic               carry_out
);
  logic [DIGIT_W-1:0] q_d;
  logic               en;

  assign at_max    = (q == DIGIT_MAX);
  assign carry_out = carry_in & at_max;
  assign en        = start | carry_in;

  always_comb begin
    q_d = q;
    if (start)         q_d = start_val;
    else if (carry_in) q_d = at_max ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/lenfield_ascii.sv
module lenfield_ascii
  import bcdlen_pkg::*;
(
  input  logic [DIGIT_W-1:0] nib,
  output logic [BYTE_W-1:0]  ch
);
  assign ch = ASCII_ZERO + {{(BYTE_W-DIGIT_W){1'b0}}, nib};
endmodule

// File: rtl/lenfield_bcd.sv
module lenfield_bcd
  import bcdlen_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_first,
  input  logic                       in_last,
  output logic [DIGITS*DIGIT_W-1:0]  len_bcd,
  output logic [BYTE_W-1:0]          len_hi,
  output logic [BYTE_W-1:0]          len_lo,
  output logic                       done,
  output logic                       overflow,
  output logic [DIGITS*BYTE_W-1:0]   dbg_ascii
);
  localparam int unsigned FIELD_W = DIGITS * DIGIT_W;

  logic              rst_sync_n;
  logic              start, step, full;
  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] is_max;
  logic              ovf_d, done_d;

  lenfield_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign start    = in_valid & in_first;
  assign full     = &is_max;
  assign step     = in_valid & ~in_first & ~full;
  assign carry[0] = step;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    lenfield_digit u_dig (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .start     (start),
      .start_val ((g == 0) ? 4'd1 : 4'd0),
      .carry_in  (carry[g]),
      .q         (len_bcd[g*DIGIT_W +: DIGIT_W]),
      .at_max    (is_max[g]),
      .carry_out (carry[g+1])
    );
    lenfield_ascii u_asc (
      .nib (len_bcd[g*DIGIT_W +: DIGIT_W]),
      .ch  (dbg_ascii[g*BYTE_W +: BYTE_W])
    );
  end

  assign len_hi = len_bcd[FIELD_W-1 -: BYTE_W];
  assign len_lo = len_bcd[BYTE_W-1:0];

  always_comb begin
    ovf_d  = overflow;
    if (start)                           ovf_d = 1'b0;
    else if (in_valid && full)           ovf_d = 1'b1;
    done_d = in_valid & in_last;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      overflow <= 1'b0;
      done     <= 1'b0;
    end else begin
      overflow <= ovf_d;
      done     <= done_d;
    end
  end
endmodule

// File: rtl/lenfield_bcd_chk.sv
module lenfield_bcd_chk #(
  parameter int unsigned DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_first,
  input logic                  in_last,
  input logic [DIGITS*4-1:0]   len_bcd,
  input logic [7:0]            len_hi,
  input logic [7:0]            len_lo,
  input logic                  done,
  input logic                  overflow,
  input logic [DIGITS*8-1:0]   dbg_ascii
);
  localparam logic [DIGITS*4-1:0] ALL9 = {DIGITS{4'h9}};
  localparam logic [DIGITS*4-1:0] ONE  = {{(DIGITS*4-1){1'b0}}, 1'b1};

  // R2
  a_r2_first_loads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |=> (len_bcd == ONE && !overflow));

  // R3
  a_r3_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
    (len_bcd[3:0] <= 4'd9 && len_bcd[7:4] <= 4'd9 &&
     len_bcd[11:8] <= 4'd9 && len_bcd[15:12] <= 4'd9));

  // R4
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(len_bcd) && $stable(overflow) && !done));

  // R6
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && len_bcd == ALL9) |=> (len_bcd == ALL9 && overflow));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(in_valid && in_first)) |=> overflow);

  // R7
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> done);

  a_r7_done_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !done);

  // R5
  a_r5_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    ({len_hi, len_lo} == len_bcd[15:0]));

  // R8
  a_r8_ascii_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ascii[7:0] == {4'h3, len_lo[3:0]} &&
     dbg_ascii[DIGITS*8-1 -: 8] == {4'h3, len_hi[7:4]}));
endmodule

bind lenfield_bcd lenfield_bcd_chk #(.DIGITS(DIGITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_first  (in_first),
  .in_last   (in_last),
  .len_bcd   (len_bcd),
  .len_hi    (len_hi),
  .len_lo    (len_lo),
  .done      (done),
  .overflow  (overflow),
  .dbg_ascii (dbg_ascii)
);

// File: tb/lenfield_bcd_bench.sv
module lenfield_bcd_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid, in_first, in_last;
  logic [15:0] len_bcd;
  logic [7:0]  len_hi, len_lo;
  logic        done, overflow;
  logic [31:0] dbg_ascii;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit prev_done = 0;

  typedef struct { int n; bit ovf; } exp_t;
  exp_t sb_q[$];

  lenfield_bcd u_lenfield_bcd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .len_bcd(len_bcd), .len_hi(len_hi), .len_lo(len_lo),
    .done(done), .overflow(overflow), .dbg_ascii(dbg_ascii)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int x = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: pushes the expected result, then sends n bytes
  task automatic send_msg(input int n);
    exp_t e;
    e.n   = (n > 9999) ? 9999 : n;
    e.ovf = (n > 9999);
    sb_q.push_back(e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_first = (i == 0);
      in_last  = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        logic [15:0] eb;
        exp_t e;
        if (prev_done) check("R7 single-cycle done", 1, 0);
        if (sb_q.size() == 0) begin
          check("R7 unexpected done", 1, 0);
        end else begin
          e  = sb_q.pop_front();
          eb = to_bcd(e.n);
          check("R3 count", {16'h0, len_bcd}, {16'h0, eb});
          check("R5 byte order", {16'h0, len_hi, len_lo},
                {16'h0, 4'(e.n/1000), 4'((e.n/100)%10), 4'((e.n/10)%10), 4'(e.n%10)});
          check("R6 overflow", {31'h0, overflow}, {31'h0, e.ovf});
          check("R8 ascii",
                dbg_ascii,
                {8'h30 + 8'(eb[15:12]), 8'h30 + 8'(eb[11:8]),
                 8'h30 + 8'(eb[7:4]),  8'h30 + 8'(eb[3:0])});
        end
      end
      prev_done <= done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      check("watchdog", 1, 0);
      finish_run();
    end
  end

  task automatic idle_probe(input logic [15:0] exp_len, input bit exp_ovf);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 0; in_first = i[0]; in_last = ~i[0];
    end
    @(negedge clk);
    in_first = 0; in_last = 0;
    check("R4 idle count", {16'h0, len_bcd}, {16'h0, exp_len});
    check("R4 idle overflow", {31'h0, overflow}, {31'h0, exp_ovf});
    check("R4 idle done", {31'h0, done}, 32'h0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_first = 0; in_last = 0;
    repeat (3) @(negedge clk);
    check("R1 reset count", {16'h0, len_bcd}, 32'h0);
    check("R1 reset done", {31'h0, done}, 32'h0);
    check("R1 reset overflow", {31'h0, overflow}, 32'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 after release", {16'h0, len_bcd}, 32'h0);

    send_msg(35);
    send_msg(150);
    idle_probe(16'h0150, 0);
    send_msg(1);
    send_msg(9);
    send_msg(10);
    send_msg(99);
    send_msg(100);
    send_msg(999);
    send_msg(1000);
    send_msg(9999);
    send_msg(10005);
    idle_probe(16'h9999, 1);
    send_msg(12);
    send_msg(2);
    repeat (4) @(negedge clk);
    check("R7 all messages completed", sb_q.size(), 0);
    finish_run();
  end
endmodule